// File: doc/BRIEF.md
# Channel Transfer Ring Pointer Tracker

This block keeps the device-side pointer state for a group of one-way logical channels. Every channel has its own circular ring of fixed-size descriptor elements in host memory. The tracker holds, per channel, the ring's base address, its last valid element index, the host-owned write index, the device-owned read index, a run bit and a pending-work flag. The host sets these through a register write port. When the host has put new elements on a ring, it writes that channel's doorbell with the new write index.

On the device side, a fetch engine reads a single offer from the block. The offer carries a channel number and the host byte address of that channel's next unserviced element. The engine retires the offer with an element count. The count may be larger than one when a descriptor was chained across several consecutive elements. A round-robin arbiter decides which channel with outstanding work is offered next. For every implemented channel the block drives a ring-empty bit and a ring-full bit. Doorbells that cannot be accepted are dropped and raise a sticky error bit.

The channel field is 8 bits wide, so up to 256 channels can be addressed. Only the first `NUM_CH` channels are implemented. Memory fetch, descriptor decode and data movement sit outside this block.

Top module: `chring_tracker`

## Requirements
- R1: After reset every implemented channel has read index 0, write index 0, base 0, last index 255 (a 256-element ring), is stopped and has no pending work. So `empty_vec` is all ones, `full_vec` is all zeros, `cons_valid` is 0 and `db_err` is 0.
- R2: A config write (`cfg_we`) to an implemented channel sets one field, chosen by `cfg_field`: 0 base address, 1 read index, 2 write index, 3 last index (ring size minus one), 4 run bit (`cfg_wdata[0]`). Clearing the run bit also clears pending work. Code 5 clears `db_err` whatever `cfg_ch` is.
- R3: `empty_vec[c]` is 1 exactly when the read index equals the write index. `full_vec[c]` is 1 exactly when the write index advanced by one element (with wrap) equals the read index.
- R4: A doorbell (`db_valid`) to an implemented, running channel loads `db_wp` into that channel's write index and sets its pending-work flag on the next clock edge.
- R5: A doorbell to a channel number at or above `NUM_CH`, or to a stopped channel, changes no channel state and sets `db_err`. `db_err` stays set until a code-5 config write. If a rejected doorbell and a clear arrive in the same cycle, the set wins.
- R6: A channel is eligible when it is running, has pending work and is not empty. When an offer is up, `cons_addr` equals the base plus the read index times 16.
- R7: Offers go round-robin. The next channel offered is the first eligible one in ascending circular order after the channel retired most recently. After reset the search starts at channel 0.
- R8: `ret_en` during a valid offer advances that channel's read index by `ret_cnt` (1 or more) elements. An index that passes the last index wraps to 0, which is the base address. The offer is withdrawn on the next cycle. Pending work is cleared when the read index reaches the write index.
- R9: While an offer is up and no retire, doorbell or config write arrives, `cons_ch` and `cons_addr` hold steady. An offer whose channel stops being eligible is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_ch | input | CH_W | Channel addressed by the config write |
| cfg_field | input | 3 | Field select (R2 codes) |
| cfg_wdata | input | ADDR_W | Config write data |
| db_valid | input | 1 | Doorbell strobe |
| db_ch | input | CH_W | Channel rung |
| db_wp | input | IDX_W | New write index carried by the doorbell |
| cons_valid | output | 1 | An offer is up for the fetch engine |
| cons_ch | output | CH_W | Channel of the offer |
| cons_addr | output | ADDR_W | Byte address of the offered element |
| ret_en | input | 1 | Retire the current offer |
| ret_cnt | input | IDX_W | Number of elements retired |
| empty_vec | output | NUM_CH | Per-channel ring-empty status |
| full_vec | output | NUM_CH | Per-channel ring-full status |
| db_err | output | 1 | Sticky rejected-doorbell flag |

## Verification
The bench targets rings whose write index sits numerically below the read index. In that case both fullness and element count depend on wrap. A design that compared the indices without modulo arithmetic would report the wrong full bit and offer the wrong address. Chained retires of several elements cross the last index. A tracker that wrapped only single steps would then run past the ring and produce an address beyond the base plus the ring size. Round-robin order is checked with several channels pending at once after a retire. A search that restarted at channel 0, or from the offered channel rather than the retired one, would produce a different channel sequence. Doorbells to stopped or unimplemented channels, and stopping a channel while its offer is up, are also exercised. A design that let those through would show a non-empty ring, a stale offer or no error bit.

// File: rtl/chring_pkg.sv
package chring_pkg;

  // Config field select codes
  typedef enum logic [2:0] {
    FLD_BASE   = 3'd0,
    FLD_RP     = 3'd1,
    FLD_WP     = 3'd2,
    FLD_LAST   = 3'd3,
    FLD_RUN    = 3'd4,
    FLD_CLRERR = 3'd5
  } cfg_field_e;

  // Each ring element occupies 16 bytes
  localparam int ELEM_SHIFT = 4;

endpackage

// File: rtl/chring_chan_ctx.sv
module chring_chan_ctx #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit,
  input  logic [2:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              db_hit,
  input  logic [IDX_W-1:0]  db_wp,
  input  logic              ret_hit,
  input  logic [IDX_W-1:0]  ret_cnt,
  output logic [ADDR_W-1:0] elem_addr,
  output logic              empty,
  output logic              full,
  output logic              run,
  output logic              eligible
);
  import chring_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  rp_q, wp_q, last_q;
  logic              run_q, pend_q;
  cfg_field_e        fld;

  // Advance index p by k elements in a ring whose last index is lst
  function automatic logic [IDX_W-1:0] ring_adv(input logic [IDX_W-1:0] p,
                                                input logic [IDX_W-1:0] k,
                                                input logic [IDX_W-1:0] lst);
    logic [IDX_W:0] s, lim;
    s   = {1'b0, p} + {1'b0, k};
    lim = {1'b0, lst} + {{IDX_W{1'b0}}, 1'b1};
    if (s >= lim) s = s - lim;
    return s[IDX_W-1:0];
  endfunction

  // Host byte address of element i of a ring starting at b
  function automatic logic [ADDR_W-1:0] elem_at(input logic [ADDR_W-1:0] b,
                                                input logic [IDX_W-1:0]  i);
    return b + (ADDR_W'(i) << ELEM_SHIFT);
  endfunction

  // Named internal events
  logic [IDX_W-1:0] rp_after;
  logic [IDX_W-1:0] wp_plus1;
  logic             ret_drains;

  assign fld        = cfg_field_e'(cfg_field);
  assign rp_after   = ring_adv(rp_q, ret_cnt, last_q);
  assign wp_plus1   = ring_adv(wp_q, {{(IDX_W-1){1'b0}}, 1'b1}, last_q);
  assign ret_drains = ret_hit && (rp_after == wp_q);

  assign empty     = (rp_q == wp_q);
  assign full      = (wp_plus1 == rp_q);
  assign run       = run_q;
  assign eligible  = run_q && pend_q && !empty;
  assign elem_addr = elem_at(base_q, rp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      rp_q   <= '0;
      wp_q   <= '0;
      last_q <= '1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ret_hit) rp_q <= rp_after;
      if (ret_drains) pend_q <= 1'b0;
      if (db_hit) begin
        wp_q   <= db_wp;
        pend_q <= 1'b1;
      end
      // Config writes take priority over doorbell and retire
      if (cfg_hit) begin
        case (fld)
          FLD_BASE: base_q <= cfg_wdata;
          FLD_RP:   rp_q   <= cfg_wdata[IDX_W-1:0];
          FLD_WP:   wp_q   <= cfg_wdata[IDX_W-1:0];
          FLD_LAST: last_q <= cfg_wdata[IDX_W-1:0];
          FLD_RUN: begin
            run_q <= cfg_wdata[0];
            if (!cfg_wdata[0]) pend_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  db_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_hit && !cfg_hit |=> pend_q && (wp_q == $past(db_wp)));

  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q != '0) |-> !(empty && full));

endmodule

// File: rtl/chring_rr_arb.sv
module chring_rr_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] prev,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  int c;

  // Search starts one past the previously retired channel
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    c         = 0;
    for (int k = 1; k <= N; k++) begin
      c = int'(prev) + k;
      if (c >= N) c = c - N;
      if (!gnt_valid && req[c]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(c);
      end
    end
  end

  // R7
  always_comb begin
    if (gnt_valid) begin
      grant_req_chk: assert (req[gnt_idx]);
    end
  end

endmodule

// File: rtl/chring_tracker.sv
module chring_tracker #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [2:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              db_valid,
  input  logic [CH_W-1:0]   db_ch,
  input  logic [IDX_W-1:0]  db_wp,
  output logic              cons_valid,
  output logic [CH_W-1:0]   cons_ch,
  output logic [ADDR_W-1:0] cons_addr,
  input  logic              ret_en,
  input  logic [IDX_W-1:0]  ret_cnt,
  output logic [NUM_CH-1:0] empty_vec,
  output logic [NUM_CH-1:0] full_vec,
  output logic              db_err
);
  import chring_pkg::*;

  localparam int CI_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W:0] NUM_CH_V = (CH_W+1)'(NUM_CH);

  logic [ADDR_W-1:0] addr_arr [NUM_CH];
  logic [NUM_CH-1:0] run_vec, elig_vec;

  // Named internal events
  logic            db_in_range, cfg_in_range;
  logic [CI_W-1:0] db_idx;
  logic            db_accept, db_reject, clr_err, retire_fire;
  logic            arb_valid;
  logic [CI_W-1:0] arb_idx;

  logic            off_valid_q, err_q;
  logic [CI_W-1:0] off_idx_q, prev_q;

  assign db_in_range  = ({1'b0, db_ch} < NUM_CH_V);
  assign cfg_in_range = ({1'b0, cfg_ch} < NUM_CH_V);
  assign db_idx       = db_ch[CI_W-1:0];
  assign db_accept    = db_valid && db_in_range && run_vec[db_idx];
  assign db_reject    = db_valid && !db_accept;
  assign clr_err      = cfg_we && (cfg_field == FLD_CLRERR);

  assign cons_valid  = off_valid_q && elig_vec[off_idx_q];
  assign cons_ch     = CH_W'(off_idx_q);
  assign cons_addr   = addr_arr[off_idx_q];
  assign retire_fire = ret_en && cons_valid;
  assign db_err      = err_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cfg_hit_g, db_hit_g, ret_hit_g;
    assign cfg_hit_g = cfg_we && cfg_in_range && (cfg_ch == CH_W'(g)) &&
                       (cfg_field != FLD_CLRERR);
    assign db_hit_g  = db_accept && (db_idx == CI_W'(g));
    assign ret_hit_g = retire_fire && (off_idx_q == CI_W'(g));

    chring_chan_ctx #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_hit   (cfg_hit_g),
      .cfg_field (cfg_field),
      .cfg_wdata (cfg_wdata),
      .db_hit    (db_hit_g),
      .db_wp     (db_wp),
      .ret_hit   (ret_hit_g),
      .ret_cnt   (ret_cnt),
      .elem_addr (addr_arr[g]),
      .empty     (empty_vec[g]),
      .full      (full_vec[g]),
      .run       (run_vec[g]),
      .eligible  (elig_vec[g])
    );
  end

  chring_rr_arb #(.N(NUM_CH), .IW(CI_W)) u_arb (
    .req       (elig_vec),
    .prev      (prev_q),
    .gnt_valid (arb_valid),
    .gnt_idx   (arb_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_valid_q <= 1'b0;
      off_idx_q   <= '0;
      prev_q      <= CI_W'(NUM_CH - 1);
    end else if (retire_fire) begin
      off_valid_q <= 1'b0;
      prev_q      <= off_idx_q;
    end else if (off_valid_q && !elig_vec[off_idx_q]) begin
      off_valid_q <= 1'b0;
    end else if (!off_valid_q && arb_valid) begin
      off_valid_q <= 1'b1;
      off_idx_q   <= arb_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (db_reject) err_q <= 1'b1;
    else if (clr_err)   err_q <= 1'b0;
  end

  // R5
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_reject |=> db_err);

  // R8
  retire_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> !cons_valid);

  // R9
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid && !ret_en && !cfg_we && !db_valid |=>
      cons_valid && $stable(cons_ch) && $stable(cons_addr));

endmodule

// File: tb/chring_tracker_test.sv
module chring_tracker_test;

  localparam int NUM_CH = 8;
  localparam int CH_W   = 8;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 32;

  localparam logic [2:0] F_BASE = 3'd0, F_RP = 3'd1, F_WP = 3'd2,
                         F_LAST = 3'd3, F_RUN = 3'd4, F_CLR = 3'd5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CH_W-1:0]   cfg_ch = '0;
  logic [2:0]        cfg_field = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              db_valid = 1'b0;
  logic [CH_W-1:0]   db_ch = '0;
  logic [IDX_W-1:0]  db_wp = '0;
  logic              cons_valid;
  logic [CH_W-1:0]   cons_ch;
  logic [ADDR_W-1:0] cons_addr;
  logic              ret_en = 1'b0;
  logic [IDX_W-1:0]  ret_cnt = '0;
  logic [NUM_CH-1:0] empty_vec, full_vec;
  logic              db_err;

  always #4 clk = ~clk;

  chring_tracker #(.NUM_CH(NUM_CH), .CH_W(CH_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .db_valid(db_valid), .db_ch(db_ch), .db_wp(db_wp),
    .cons_valid(cons_valid), .cons_ch(cons_ch), .cons_addr(cons_addr),
    .ret_en(ret_en), .ret_cnt(ret_cnt),
    .empty_vec(empty_vec), .full_vec(full_vec), .db_err(db_err)
  );

  typedef struct packed {
    logic [7:0]  ch;
    logic [31:0] addr;
    logic [7:0]  cnt;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int ch, input logic [2:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ring(input int ch, input int wp);
    @(negedge clk);
    db_valid = 1'b1; db_ch = CH_W'(ch); db_wp = IDX_W'(wp);
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic expect_offer(input int ch, input logic [31:0] addr, input int cnt);
    exp_t e;
    e.ch = 8'(ch); e.addr = addr; e.cnt = 8'(cnt);
    sb_q.push_back(e);
  endtask

  task automatic drain(input string req);
    int n = 0;
    mon_en = 1'b1;
    while (sb_q.size() != 0 && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    check({req, " queue drained"}, 64'(sb_q.size()), 64'd0);
    check({req, " no further offer"}, 64'(cons_valid), 64'd0);
  endtask

  // Monitor: compare each offer against the scoreboard, then retire it
  initial begin
    forever begin
      @(negedge clk);
      if (ret_en) begin
        ret_en = 1'b0;
      end else if (mon_en && cons_valid) begin
        if (sb_q.size() == 0) begin
          check("R7 unexpected offer channel", 64'(cons_ch), 64'hFF);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check("R7 offered channel", 64'(cons_ch), 64'(e.ch));
          check("R6 offered element address", 64'(cons_addr), 64'(e.addr));
          ret_cnt = e.cnt;
          ret_en  = 1'b1;
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 empty after reset", 64'(empty_vec), 64'hFF);
    check("R1 full after reset", 64'(full_vec), 64'h00);
    check("R1 no offer after reset", 64'(cons_valid), 64'd0);
    check("R1 error clear after reset", 64'(db_err), 64'd0);

    // R1 default 256-element ring: write index 255 with read index 0 is full
    cfg_wr(7, F_RUN, 32'd1);
    ring(7, 255);
    check("R1 R3 default ring full", 64'(full_vec[7]), 64'd1);
    @(negedge clk);
    check("R6 default offer valid", 64'(cons_valid), 64'd1);
    check("R6 default offer channel", 64'(cons_ch), 64'd7);
    check("R6 default offer address", 64'(cons_addr), 64'd0);
    ring(7, 0);
    @(negedge clk);
    check("R3 ring empty after wp returns", 64'(empty_vec[7]), 64'd1);
    check("R9 offer withdrawn when not eligible", 64'(cons_valid), 64'd0);

    // R2 programming
    cfg_wr(0, F_BASE, 32'h4000); cfg_wr(0, F_LAST, 32'd7);  cfg_wr(0, F_RUN, 32'd1);
    cfg_wr(1, F_BASE, 32'h1000); cfg_wr(1, F_LAST, 32'd7);  cfg_wr(1, F_RUN, 32'd1);
    cfg_wr(3, F_BASE, 32'h2000); cfg_wr(3, F_LAST, 32'd3);
    cfg_wr(3, F_RP, 32'd2);      cfg_wr(3, F_WP, 32'd2);    cfg_wr(3, F_RUN, 32'd1);
    cfg_wr(5, F_BASE, 32'h3000); cfg_wr(5, F_LAST, 32'd15); cfg_wr(5, F_RUN, 32'd1);
    cfg_wr(9, F_WP, 32'd4);
    check("R2 rings empty after setup", 64'(empty_vec), 64'hFF);
    check("R2 no offer without doorbell", 64'(cons_valid), 64'd0);

    // R5 rejected doorbells
    ring(6, 5);
    check("R5 stopped channel sets error", 64'(db_err), 64'd1);
    check("R5 stopped channel ring unchanged", 64'(empty_vec[6]), 64'd1);
    @(negedge clk);
    check("R5 stopped channel not offered", 64'(cons_valid), 64'd0);
    cfg_wr(2, F_CLR, 32'd0);
    check("R2 R5 error cleared", 64'(db_err), 64'd0);
    ring(200, 1);
    check("R5 unimplemented channel sets error", 64'(db_err), 64'd1);
    check("R5 unimplemented channel state untouched", 64'(empty_vec), 64'hFF);
    cfg_wr(0, F_CLR, 32'd0);

    // R3 R4 wrapped write index making ring 3 full (rp 2, wp 1, last 3)
    ring(3, 1);
    check("R4 doorbell loads write index", 64'(empty_vec[3]), 64'd0);
    check("R3 wrapped ring full", 64'(full_vec[3]), 64'd1);
    ring(1, 2);
    ring(5, 1);
    ring(0, 1);
    check("R3 ring 1 not full", 64'(full_vec[1]), 64'd0);
    check("R9 held offer channel", 64'(cons_ch), 64'd3);
    repeat (3) @(negedge clk);
    check("R9 offer still valid", 64'(cons_valid), 64'd1);
    check("R9 held offer channel stable", 64'(cons_ch), 64'd3);
    check("R9 held offer address stable", 64'(cons_addr), 64'h2020);

    // R7 R8 round robin with a chained retire crossing the wrap
    expect_offer(3, 32'h2020, 2);
    expect_offer(5, 32'h3000, 1);
    expect_offer(0, 32'h4000, 1);
    expect_offer(1, 32'h1000, 1);
    expect_offer(3, 32'h2000, 1);
    expect_offer(1, 32'h1010, 1);
    drain("R7 R8 round robin");
    check("R8 all rings empty after retire", 64'(empty_vec), 64'hFF);
    check("R8 no ring full", 64'(full_vec), 64'h00);

    // R8 long chained retire wraps back to base (ring 1: rp 2, wp 1)
    ring(1, 1);
    check("R3 ring 1 full after wrap doorbell", 64'(full_vec[1]), 64'd1);
    expect_offer(1, 32'h1020, 6);
    expect_offer(1, 32'h1000, 1);
    drain("R8 wrap to base");
    check("R8 ring 1 empty", 64'(empty_vec[1]), 64'd1);

    // R2 R9 stopping a channel withdraws its offer and pending work
    ring(0, 3);
    @(negedge clk);
    check("R6 ring 0 offered", 64'(cons_valid), 64'd1);
    cfg_wr(0, F_RUN, 32'd0);
    @(negedge clk);
    check("R9 stopped channel offer withdrawn", 64'(cons_valid), 64'd0);
    cfg_wr(0, F_RUN, 32'd1);
    repeat (2) @(negedge clk);
    check("R2 restart does not restore pending", 64'(cons_valid), 64'd0);
    ring(0, 3);
    expect_offer(0, 32'h4010, 2);
    drain("R8 chained retire ring 0");
    check("R8 ring 0 empty", 64'(empty_vec[0]), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule